// File: doc/BRIEF.md
# Parallel One-Step Majority-Logic Corrector for a 15-bit Cyclic LDPC Code

This block repairs 15-bit words of a cyclic (15,7,5) low-density parity-check code that are read back from storage. Every bit position has its own private decider. Each decider forms the four parity checks that meet only at that bit and inverts the bit when a majority of those checks fail. Because the minimum distance is 5, any word with at most two flipped bits comes out as the original codeword. The block is fed one word per cycle and returns the repaired word two cycles later.

The block sits in front of an external fault-secure detector, which checks the repaired word. If that detector finds the output suspect, it raises a repeat request. The corrector then feeds the raw word behind the current output through its pipeline again. The fifteen deciders share no gates, so a transient fault inside one of them can spoil at most one output bit.

Top module: `mlc_corrector`

## Requirements
- R1: A word presented with `in_valid` high at clock edge k shows up on `out_word`, with `out_valid` high, right after edge k+2. Two cycles is the whole latency.
- R2: `out_valid` is high only two cycles after an accepted input or an honoured repeat.
- R3: A valid codeword is a word for which every row check is 0, with row j covering bits j, j+8, j+12 and j+14 modulo 15. Such a word passes through unchanged.
- R4: Any codeword with exactly one inverted bit is returned as the original codeword.
- R5: Any codeword with exactly two inverted bits is returned as the original codeword.
- R6: Output bit i is input bit i inverted exactly when at least 3 of the rows i, i+7, i+3 and i+1 (modulo 15) have odd parity over their four bits. With 2 or fewer failing rows, the bit is passed unchanged. This holds for any input word, including words with more than two errors.
- R7: When `redo_req` is high while `out_valid` is high, the raw word that produced the current output re-enters the pipeline. Its corrected value appears again two cycles later. The `in_valid` and `in_word` inputs of that cycle are ignored.
- R8: `redo_req` has no effect while `out_valid` is low.
- R9: While reset is held, `out_valid` and `out_word` are 0.
- R10: Words sent on consecutive cycles come out on consecutive cycles, in order and without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received word is present this cycle |
| in_word | input | 15 | Received word, bit i is code position i |
| redo_req | input | 1 | Detector asks for the current output word to be corrected again |
| out_valid | output | 1 | `out_word` holds a corrected word |
| out_word | output | 15 | Corrected word |

## Verification
The assertions take for granted that `in_valid`, `in_word` and `redo_req` are stable and known at each rising edge. The codeword check on the input is only meaningful when the upstream source really sends words from the code. The stimulus changes inputs only on the falling edge and builds every codeword by filtering all 32768 words through the row checks. It then sends every codeword, every single-bit corruption and every two-bit corruption of each. Random words with three or more errors follow, together with repeat requests raised both while the output is valid and while it is idle.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
    localparam int N = 15;          // code length
    localparam int W = 4;           // row weight, checks per bit
    localparam int THRESH = 3;      // failing checks needed to invert a bit
    localparam int unsigned DIFF [W] = '{0, 8, 12, 14};

    typedef logic [N-1:0] word_t;
    typedef logic [W-1:0] chk_t;

    // bit position of the m-th member of row r
    function automatic int row_bit(input int r, input int m);
        return (r + int'(DIFF[m])) % N;
    endfunction

    // the k-th row that contains bit b
    function automatic int chk_row(input int b, input int k);
        return (b - int'(DIFF[k]) + N) % N;
    endfunction

    // full syndrome, used only by checks
    function automatic word_t syndrome(input word_t w);
        word_t s;
        for (int r = 0; r < N; r++) begin
            s[r] = 1'b0;
            for (int m = 0; m < W; m++) s[r] ^= w[row_bit(r, m)];
        end
        return s;
    endfunction
endpackage

// File: rtl/mlc_check_sum.sv
module mlc_check_sum
    import mlc_pkg::*;
#(
    parameter int BIT = 0
) (
    input  word_t word,
    output chk_t  chk
);
    // four rows orthogonal on BIT, each a private tree of 2-input XORs
    for (genvar k = 0; k < W; k++) begin : g_row
        localparam int ROW = chk_row(BIT, k);
        logic lo, hi;
        assign lo = word[row_bit(ROW, 0)] ^ word[row_bit(ROW, 1)];
        assign hi = word[row_bit(ROW, 2)] ^ word[row_bit(ROW, 3)];
        assign chk[k] = lo ^ hi;
    end
endmodule

// File: rtl/mlc_majority.sv
module mlc_majority
    import mlc_pkg::*;
(
    input  chk_t chk,
    output logic hit
);
    // 4-input bit sorting network, five compare-exchange cells
    logic a0, a1, a2, a3;
    logic b0, b1, b2, b3;
    logic s1, s2;

    assign a0 = chk[0] | chk[1];
    assign a1 = chk[0] & chk[1];
    assign a2 = chk[2] | chk[3];
    assign a3 = chk[2] & chk[3];
    assign b0 = a0 | a2;
    assign b2 = a0 & a2;
    assign b1 = a1 | a3;
    assign b3 = a1 & a3;
    assign s1 = b1 | b2;
    assign s2 = b1 & b2;

    // sorted high-to-low: b0, s1, s2, b3; THRESH = 3 picks the third
    logic [W-1:0] sorted;
    assign sorted = {b0, s1, s2, b3};
    assign hit = sorted[W - THRESH];
endmodule

// File: rtl/mlc_bit_slice.sv
module mlc_bit_slice
    import mlc_pkg::*;
#(
    parameter int BIT = 0
) (
    input  word_t word_in,   // stage-1 source word
    output chk_t  chk_d,     // checks for BIT, to be registered
    input  chk_t  chk_q,     // registered checks
    input  logic  raw_q,     // registered raw bit
    output logic  fix_d      // decided bit, to be registered
);
    logic hit;

    mlc_check_sum #(.BIT(BIT)) i_sum (
        .word (word_in),
        .chk  (chk_d)
    );

    mlc_majority i_maj (
        .chk (chk_q),
        .hit (hit)
    );

    assign fix_d = raw_q ^ hit;
endmodule

// File: rtl/mlc_corrector.sv
module mlc_corrector
    import mlc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [14:0] in_word,
    input  logic        redo_req,
    output logic        out_valid,
    output logic [14:0] out_word
);
    typedef struct packed {
        logic                v1;
        word_t               raw1;
        logic [N-1:0][W-1:0] chk1;
        logic                v2;
        word_t               raw2;
        word_t               fix2;
    } pipe_t;

    pipe_t st_d, st_q;

    logic  redo_take;
    word_t src;
    chk_t  chk_d [N];
    word_t fix_d;

    assign redo_take = redo_req & st_q.v2;
    assign src       = redo_take ? st_q.raw2 : in_word;

    for (genvar i = 0; i < N; i++) begin : g_slice
        mlc_bit_slice #(.BIT(i)) i_slice (
            .word_in (src),
            .chk_d   (chk_d[i]),
            .chk_q   (st_q.chk1[i]),
            .raw_q   (st_q.raw1[i]),
            .fix_d   (fix_d[i])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.v1   = in_valid | redo_take;
        st_d.raw1 = src;
        for (int i = 0; i < N; i++) st_d.chk1[i] = chk_d[i];
        st_d.v2   = st_q.v1;
        st_d.raw2 = st_q.raw1;
        st_d.fix2 = fix_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v2;
    assign out_word  = st_q.fix2;

    // R1: accepted input is delivered two cycles later
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R2: no output without a source two cycles earlier
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !(redo_req && out_valid)) |=> ##1 !out_valid);

    // R3: a clean codeword passes unchanged
    a_r3_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(redo_req && out_valid) && syndrome(in_word) == '0)
        |=> ##1 (out_word == $past(in_word, 2)));

    // R7: a repeat reproduces the same corrected word
    a_r7_repeat_same: assert property (@(posedge clk) disable iff (!rst_n)
        (redo_req && out_valid) |=> ##1 (out_valid && out_word == $past(out_word, 2)));

    // R8: an idle repeat request creates nothing
    a_r8_idle_redo: assert property (@(posedge clk) disable iff (!rst_n)
        (redo_req && !out_valid && !in_valid) |=> ##1 !out_valid);
endmodule

// File: tb/test_mlc_corrector.sv
`timescale 1ns/1ps
module test_mlc_corrector;
    localparam int NB = 15;
    localparam time TCK = 5ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NB-1:0] in_word = '0;
    logic redo_req = 1'b0;
    logic out_valid;
    logic [NB-1:0] out_word;

    int n_checks = 0;
    int n_errors = 0;

    always #(TCK/2) clk = ~clk;

    mlc_corrector i_mlc_corrector (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_word (in_word),
        .redo_req (redo_req), .out_valid (out_valid), .out_word (out_word)
    );

    logic [NB-1:0] cw [128];

    // expectation pipeline
    bit            s1_v = 0, s2_v = 0;
    logic [NB-1:0] s1_e, s2_e;
    string         s1_t = "R2", s2_t = "R2";

    function automatic bit row_par(input logic [NB-1:0] w, input int r);
        return w[r % NB] ^ w[(r + 8) % NB] ^ w[(r + 12) % NB] ^ w[(r + 14) % NB];
    endfunction

    function automatic logic [NB-1:0] model(input logic [NB-1:0] w);
        logic [NB-1:0] o;
        for (int i = 0; i < NB; i++) begin
            int cnt;
            cnt = row_par(w, i) + row_par(w, (i + 7) % NB)
                + row_par(w, (i + 3) % NB) + row_par(w, (i + 1) % NB);
            o[i] = (cnt >= 3) ? ~w[i] : w[i];
        end
        return o;
    endfunction

    task automatic step(input bit v, input logic [NB-1:0] w, input bit rd,
                        input logic [NB-1:0] exp_w, input string tag);
        bit n_v;
        logic [NB-1:0] n_e;
        string n_t;
        @(negedge clk);
        n_checks++;
        if (out_valid !== s2_v) begin
            n_errors++;
            $display("FAIL %s (R1 or R2 valid): out_valid=%0b expected %0b", s2_t, out_valid, s2_v);
        end else if (s2_v && out_word !== s2_e) begin
            n_errors++;
            $display("FAIL %s: out_word=%h expected %h", s2_t, out_word, s2_e);
        end
        if (rd && s2_v) begin
            n_v = 1; n_e = s2_e; n_t = {"R7 repeat of ", s2_t};
        end else begin
            n_v = v; n_e = exp_w; n_t = v ? tag : (rd ? "R8" : "R2");
        end
        s2_v = s1_v; s2_e = s1_e; s2_t = s1_t;
        s1_v = n_v;  s1_e = n_e;  s1_t = n_t;
        in_valid = v; in_word = w; redo_req = rd;
    endtask

    initial begin
        #(TCK * 200000);
        n_errors++;
        $display("FAIL R1: watchdog expired, out_valid=%0b expected run to end", out_valid);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int ncw;
        void'($urandom(32'd20240611));
        ncw = 0;
        for (int w = 0; w < 32768; w++) begin
            bit ok;
            ok = 1;
            for (int r = 0; r < NB; r++) if (row_par(15'(w), r)) ok = 0;
            if (ok && ncw < 128) begin cw[ncw] = 15'(w); ncw++; end
        end
        n_checks++;
        if (ncw != 128) begin
            n_errors++;
            $display("FAIL R3: codeword count=%0d expected 128", ncw);
        end

        // R9: reset state
        in_word = '1;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_word !== '0) begin
            n_errors++;
            $display("FAIL R9: valid=%0b word=%h expected 0 and 0000", out_valid, out_word);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3, R4, R5, R10: exhaustive back-to-back stream
        for (int c = 0; c < 128; c++) begin
            step(1, cw[c], 0, cw[c], "R3");
            for (int a = 0; a < NB; a++) begin
                step(1, cw[c] ^ (15'd1 << a), 0, cw[c], "R4");
                for (int b = a + 1; b < NB; b++)
                    step(1, cw[c] ^ (15'd1 << a) ^ (15'd1 << b), 0, cw[c], "R5 R10");
            end
        end
        repeat (3) step(0, '0, 0, '0, "R2");

        // R7: directed repeat with a competing input that must be ignored
        step(1, cw[5] ^ 15'h4001, 0, cw[5], "R5");
        step(0, '0, 0, '0, "R2");
        step(1, cw[9], 1, cw[9], "R7 ignored input");
        step(0, '0, 0, '0, "R2");
        step(0, '0, 0, '0, "R2");
        // R8: repeat while idle
        step(0, '0, 1, '0, "R8");
        step(0, '0, 1, '0, "R8");
        repeat (3) step(0, '0, 0, '0, "R2");

        // R6: heavy error patterns, plus random valid gaps and repeats
        for (int n = 0; n < 3000; n++) begin
            logic [NB-1:0] w;
            int ne;
            w = cw[$urandom_range(127)];
            ne = $urandom_range(6, 3);
            for (int e = 0; e < ne; e++) w[$urandom_range(NB - 1)] ^= 1'b1;
            step($urandom_range(3) != 0, w, $urandom_range(7) == 0, model(w), "R6");
        end
        repeat (4) step(0, '0, 0, '0, "R2");

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule